// File: doc/BRIEF.md
# Paged PHY Management Access Controller

The block lets a host reach PHY registers that sit behind a page selector. The host fills three 32-bit control words and then sets a start bit. The block drives the MDC clock and the MDIO data line and issues the serial frames needed for the access. It then clears the start bit, and the host reads that bit as busy.

Each access to one PHY takes up to three frames. The first frame writes the page number into PHY register 31. The second frame reads or writes the target register. The third frame, when it is enabled, writes the parked page number back into register 31.

- A read addresses one PHY by number. Its 16-bit result lands in the low half of the data word.
- A write uses a 32-bit port mask. It visits every selected PHY in ascending port order before busy clears.

The host keeps the parked-page setting in the command word, and the block preserves it.

Top module: `mdio_paged_ctrl`

## Requirements
- R1: After reset, all three control words read zero, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: Writing word 1 with bit 0 set starts a command, and bit 0 (busy) stays 1 until the command ends. While busy, host writes to any word are dropped and start nothing.
- R3: A read (word 1 bit 2 = 0) goes to the PHY numbered by word 2 bits 31:16. The block writes the page (word 1 bits 14:3) to PHY register 31, then reads the register given by word 1 bits 24:20. The result goes to word 2 bits 15:0, and every other bit of word 1 reads back unchanged when busy clears.
- R4: A write (word 1 bit 2 = 1) visits every PHY whose bit is set in the mask in word 0, in ascending order. For each PHY it writes the page to register 31 and then writes word 2 bits 31:16 to the target register.
- R5: A read of a port number above 31 sends no frame, puts 0xFFFF in word 2 bits 15:0 and clears busy within 4 cycles.
- R6: Each frame is sent MSB first: 32 ones, start bits 01, opcode 01 for write or 10 for read, 5-bit PHY address, 5-bit register, a 2-bit turnaround and 16 data bits. On writes the block drives the turnaround as 10.
- R7: When word 1 bit 1 is set, a third frame writes the park value (word 1 bits 19:15) to register 31 of each visited PHY. When bit 1 is clear, that frame is left out.
- R8: MDC has a period of 2×HALF system clocks, high for the second half of each bit slot. MDIO changes only while MDC is low, and the PHY input is sampled on the rising edge of MDC.
- R9: A write with an empty mask sends no frame and clears busy.
- R10: During a read frame, the block releases MDIO for the turnaround and the 16 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Word select: 0 mask, 1 command, 2 port/data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word selected by host_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two things can happen in the same command window: a running command writes its own completion into the control words, and the host writes to those same words. The bench sends host writes to the mask, data and command words in the middle of a read. It then checks that busy was still high at that point and that only the expected three frames appeared. It also checks that, after completion, the mask and port field keep their old values and only the read result was written. A separate watch on the bench PHY model counts any slot in which the block drives MDIO during a read's turnaround or data bits.

// File: rtl/mdio_pg_pkg.sv
package mdio_pg_pkg;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int PAGE_W     = 12;
    localparam int DATA_W     = 16;
    localparam int PARK_W     = 5;
    localparam int FRAME_LEN  = 64;
    localparam int TA_SLOT    = 46;
    localparam int DATA_SLOT  = 48;
    localparam logic [REG_AW-1:0] PAGE_REG = 5'd31;

    // command word field positions
    localparam int CMD_START  = 0;
    localparam int CMD_PARKEN = 1;
    localparam int CMD_WRITE  = 2;
    localparam int CMD_PG_LO  = 3;
    localparam int CMD_PK_LO  = 15;
    localparam int CMD_RG_LO  = 20;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_SCAN, SQ_PAGE, SQ_ACC, SQ_PARK
    } sq_state_e;
endpackage

// File: rtl/pg_mdio_frame.sv
module pg_mdio_frame
    import mdio_pg_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd,
    input  logic [PHY_AW-1:0] phy,
    input  logic [REG_AW-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int SLOT = 2 * HALF;
    localparam int CW   = (SLOT > 2) ? $clog2(SLOT) : 1;
    localparam int IW   = $clog2(FRAME_LEN);

    typedef struct packed {
        logic                 active;
        logic [IW-1:0]        idx;
        logic [CW-1:0]        cnt;
        logic [FRAME_LEN-1:0] frame;
        logic                 rd;
        logic [DATA_W-1:0]    sh;
        logic                 mdc;
        logic                 mo;
        logic                 oe;
        logic                 done;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (go) begin
                d.active = 1'b1;
                d.idx    = '0;
                d.cnt    = '0;
                d.frame  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01),
                            phy, regn, 2'b10, wdata};
                d.rd     = rd;
                d.mdc    = 1'b0;
                d.mo     = 1'b1;
                d.oe     = 1'b1;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(HALF - 1)) begin
                d.mdc = 1'b1;
                if (q.rd && q.idx >= IW'(DATA_SLOT))
                    d.sh = {q.sh[DATA_W-2:0], mdio_i};
            end
            if (q.cnt == CW'(SLOT - 1)) begin
                d.cnt = '0;
                d.mdc = 1'b0;
                if (q.idx == IW'(FRAME_LEN - 1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                    d.oe     = 1'b0;
                    d.mo     = 1'b0;
                end else begin
                    d.idx   = q.idx + 1'b1;
                    d.frame = q.frame << 1;
                    d.mo    = q.frame[FRAME_LEN-2];
                    d.oe    = !(q.rd && (q.idx + 1'b1) >= IW'(TA_SLOT));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle    = !q.active;
    assign done    = q.done;
    assign rdata   = q.sh;
    assign mdc     = q.mdc;
    assign mdio_o  = q.mo;
    assign mdio_oe = q.oe;

    // R8: data line only moves while the clock is low
    a_r8_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mdc && $past(q.mdc)) |-> $stable(q.mo));
endmodule

// File: rtl/pg_mdio_seq.sv
module pg_mdio_seq
    import mdio_pg_pkg::*;
#(
    parameter int PORTS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_AW-1:0] regn,
    input  logic [PARK_W-1:0] park,
    input  logic              park_en,
    input  logic [15:0]       port,
    input  logic [PORTS-1:0]  mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic              f_idle,
    input  logic              f_done,
    input  logic [DATA_W-1:0] f_rdata,
    output logic              f_go,
    output logic              f_rd,
    output logic [PHY_AW-1:0] f_phy,
    output logic [REG_AW-1:0] f_reg,
    output logic [DATA_W-1:0] f_wdata,
    output logic              done,
    output logic              res_we,
    output logic [DATA_W-1:0] res_data
);
    localparam int PW = $clog2(PORTS);

    typedef struct packed {
        sq_state_e         st;
        logic [PW:0]       cur;
        logic              launched;
        logic              done;
        logic              res_we;
        logic [DATA_W-1:0] res;
    } sq_t;

    sq_t q, d;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.res_we = 1'b0;
        f_go     = 1'b0;
        f_rd     = 1'b0;
        f_phy    = PHY_AW'(q.cur);
        f_reg    = PAGE_REG;
        f_wdata  = DATA_W'(page);
        unique case (q.st)
            SQ_IDLE: if (start) begin
                if (is_write) begin
                    d.cur = '0;
                    d.st  = SQ_SCAN;
                end else if (port >= 16'(PORTS)) begin
                    d.res_we = 1'b1;
                    d.res    = '1;
                    d.done   = 1'b1;
                end else begin
                    d.cur = (PW+1)'(port);
                    d.st  = SQ_PAGE;
                end
            end
            SQ_SCAN: begin
                if (q.cur == (PW+1)'(PORTS)) begin
                    d.done = 1'b1;
                    d.st   = SQ_IDLE;
                end else if (mask[q.cur[PW-1:0]]) begin
                    d.st = SQ_PAGE;
                end else begin
                    d.cur = q.cur + 1'b1;
                end
            end
            default: begin
                if (q.st == SQ_ACC) begin
                    f_rd    = !is_write;
                    f_reg   = regn;
                    f_wdata = wdata;
                end else if (q.st == SQ_PARK) begin
                    f_wdata = DATA_W'(park);
                end
                if (!q.launched) begin
                    f_go       = 1'b1;
                    d.launched = 1'b1;
                end else if (f_done) begin
                    d.launched = 1'b0;
                    if (q.st == SQ_PAGE) begin
                        d.st = SQ_ACC;
                    end else begin
                        if (q.st == SQ_ACC && !is_write) begin
                            d.res_we = 1'b1;
                            d.res    = f_rdata;
                        end
                        if (q.st == SQ_ACC && park_en) begin
                            d.st = SQ_PARK;
                        end else if (is_write) begin
                            d.cur = q.cur + 1'b1;
                            d.st  = SQ_SCAN;
                        end else begin
                            d.done = 1'b1;
                            d.st   = SQ_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SQ_IDLE, default: '0};
        else        q <= d;
    end

    assign done     = q.done;
    assign res_we   = q.res_we;
    assign res_data = q.res;

    // R2: a new command only arrives while the sequencer rests
    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == SQ_IDLE));
    // R6: a frame is never launched over one in flight
    a_r6_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
        f_go |-> f_idle);
endmodule

// File: rtl/mdio_paged_ctrl.sv
module mdio_paged_ctrl
    import mdio_pg_pkg::*;
#(
    parameter int HALF  = 2,
    parameter int PORTS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] cmd;
        logic [31:0] dat;
        logic        start;
    } rf_t;

    rf_t q, d;

    logic              s_done, s_res_we, f_go, f_rd, f_idle, f_done;
    logic [DATA_W-1:0] s_res, f_wdata, f_rdata;
    logic [PHY_AW-1:0] f_phy;
    logic [REG_AW-1:0] f_reg;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (host_we && !q.cmd[CMD_START]) begin
            unique case (host_addr)
                2'd0: d.mask = host_wdata;
                2'd1: begin
                    d.cmd   = host_wdata;
                    d.start = host_wdata[CMD_START];
                end
                2'd2: d.dat = host_wdata;
                default: ;
            endcase
        end
        if (s_done)   d.cmd[CMD_START] = 1'b0;
        if (s_res_we) d.dat[DATA_W-1:0] = s_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (host_addr)
            2'd0:    host_rdata = q.mask;
            2'd1:    host_rdata = q.cmd;
            2'd2:    host_rdata = q.dat;
            default: host_rdata = '0;
        endcase
    end

    pg_mdio_seq #(.PORTS(PORTS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (q.start),
        .is_write (q.cmd[CMD_WRITE]),
        .page     (q.cmd[CMD_PG_LO +: PAGE_W]),
        .regn     (q.cmd[CMD_RG_LO +: REG_AW]),
        .park     (q.cmd[CMD_PK_LO +: PARK_W]),
        .park_en  (q.cmd[CMD_PARKEN]),
        .port     (q.dat[31:16]),
        .mask     (q.mask[PORTS-1:0]),
        .wdata    (q.dat[31:16]),
        .f_idle   (f_idle),
        .f_done   (f_done),
        .f_rdata  (f_rdata),
        .f_go     (f_go),
        .f_rd     (f_rd),
        .f_phy    (f_phy),
        .f_reg    (f_reg),
        .f_wdata  (f_wdata),
        .done     (s_done),
        .res_we   (s_res_we),
        .res_data (s_res)
    );

    pg_mdio_frame #(.HALF(HALF)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (f_go),
        .rd      (f_rd),
        .phy     (f_phy),
        .regn    (f_reg),
        .wdata   (f_wdata),
        .mdio_i  (mdio_i),
        .idle    (f_idle),
        .done    (f_done),
        .rdata   (f_rdata),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    // R2: busy holds until the sequencer reports completion
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd[CMD_START] && !s_done) |=> q.cmd[CMD_START]);
    // R2: host writes during a command leave mask and data untouched
    a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd[CMD_START] && !s_res_we) |=> ($stable(q.mask) && $stable(q.dat)));
endmodule

// File: tb/mdio_paged_ctrl_bench.sv
module mdio_paged_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_en = 1'b0, phy_drv = 1'b1;
    wire         mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_drv : 1'b1);

    int nchk = 0, nerr = 0, cyc = 0;

    always #4 clk = ~clk;

    mdio_paged_ctrl u_mdio_paged_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // ---------------- PHY model ----------------
    logic [1:0]  f_op  [64];
    logic [4:0]  f_phy [64];
    logic [4:0]  f_reg [64];
    logic [15:0] f_dat [64];
    logic [1:0]  f_ta  [64];
    int nfr = 0, oe_bad = 0;
    logic [11:0] pg [32];
    int pos = -1, ones = 0;
    logic [12:0] hdr;
    logic [1:0]  ta;
    logic [15:0] wd, rv;

    function automatic logic [15:0] rvf(logic [4:0] p, logic [11:0] g, logic [4:0] r);
        return 16'hC000 ^ {p, r, g[5:0]};
    endfunction

    initial for (int i = 0; i < 32; i++) pg[i] = '0;

    always @(posedge mdc) begin
        logic b;
        b = mdio_line;
        if (pos < 0) begin
            if (b) ones++;
            else begin
                if (ones >= 32) begin pos = 32; hdr = '0; end
                ones = 0;
            end
        end else begin
            pos++;
            if (pos <= 45) hdr = {hdr[11:0], b};
            if (pos == 45 && hdr[11:10] == 2'b10) rv = rvf(hdr[9:5], pg[hdr[9:5]], hdr[4:0]);
            if (hdr[11:10] == 2'b10 && pos >= 46 && mdio_oe) oe_bad++;
            if (pos == 46) begin
                ta[1] = b;
                if (hdr[11:10] == 2'b10) begin phy_en <= 1'b1; phy_drv <= 1'b0; end
            end
            if (pos == 47) begin
                ta[0] = b;
                if (hdr[11:10] == 2'b10) phy_drv <= rv[15];
            end
            if (pos >= 48) begin
                wd = {wd[14:0], b};
                if (hdr[11:10] == 2'b10 && pos < 63) phy_drv <= rv[62-pos];
            end
            if (pos == 63) begin
                phy_en <= 1'b0;
                if (nfr < 64) begin
                    f_op[nfr]  = hdr[11:10];
                    f_phy[nfr] = hdr[9:5];
                    f_reg[nfr] = hdr[4:0];
                    f_dat[nfr] = (hdr[11:10] == 2'b10) ? rv : wd;
                    f_ta[nfr]  = ta;
                end
                nfr++;
                if (hdr[11:10] == 2'b01 && hdr[4:0] == 5'd31) pg[hdr[9:5]] = wd[11:0];
                pos = -1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    function automatic logic [31:0] mk(int rg, int pk, int page, bit wr, bit pken);
        return (32'(rg) << 20) | (32'(pk) << 15) | (32'(page) << 3)
             | (32'(wr) << 2) | (32'(pken) << 1) | 32'd1;
    endfunction

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        do begin host_rd(2'd1, v); n++; end while (v[0] && n < 20000);
    endtask

    task automatic run_cmd(input logic [31:0] c, output int n);
        host_wr(2'd1, c);
        wait_idle(n);
    endtask

    task automatic chk_frame(input string req, input int i, input logic [1:0] op,
                             input logic [4:0] p, input logic [4:0] r, input logic [15:0] dv);
        check(req, {f_op[i], f_phy[i], f_reg[i], f_dat[i]}, {op, p, r, dv});
        if (op == 2'b01) check({req, " TA"}, 32'(f_ta[i]), 32'h2);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 3; a++) begin
            host_rd(2'(a), v);
            check("R1 word", v, 32'h0);
        end
        check("R1 mdc/oe", {mdc, mdio_oe}, 32'h0);
    endtask

    task automatic t_read();
        logic [31:0] v, c;
        int n;
        nfr = 0; oe_bad = 0;
        c = mk(4, 7, 12'h123, 1'b0, 1'b1);
        host_wr(2'd2, {16'd5, 16'h0});
        run_cmd(c, n);
        check("R3 frames", 32'(nfr), 32'd3);
        chk_frame("R6 page frame", 0, 2'b01, 5'd5, 5'd31, 16'h0123);
        chk_frame("R3 read frame", 1, 2'b10, 5'd5, 5'd4, rvf(5'd5, 12'h123, 5'd4));
        chk_frame("R7 park frame", 2, 2'b01, 5'd5, 5'd31, 16'h0007);
        host_rd(2'd2, v);
        check("R3 result", v, {16'd5, rvf(5'd5, 12'h123, 5'd4)});
        host_rd(2'd1, v);
        check("R3 cmd kept", v, c & ~32'd1);
        check("R10 released", 32'(oe_bad), 32'd0);
    endtask

    task automatic t_nopark();
        logic [31:0] v;
        int n;
        nfr = 0;
        host_wr(2'd2, {16'd12, 16'h0});
        run_cmd(mk(7, 9, 12'h0AB, 1'b0, 1'b0), n);
        check("R7 frames", 32'(nfr), 32'd2);
        chk_frame("R7 read frame", 1, 2'b10, 5'd12, 5'd7, rvf(5'd12, 12'h0AB, 5'd7));
        host_rd(2'd2, v);
        check("R7 result", v[15:0], 32'(rvf(5'd12, 12'h0AB, 5'd7)));
    endtask

    task automatic t_write();
        int n, k;
        int ports[3] = '{0, 3, 17};
        nfr = 0; k = 0;
        host_wr(2'd0, 32'h0002_0009);
        host_wr(2'd2, {16'hBEEF, 16'h0});
        run_cmd(mk(9, 3, 12'h002, 1'b1, 1'b1), n);
        check("R4 frames", 32'(nfr), 32'd9);
        foreach (ports[i]) begin
            chk_frame("R4 page", k,     2'b01, 5'(ports[i]), 5'd31, 16'h0002);
            chk_frame("R4 data", k + 1, 2'b01, 5'(ports[i]), 5'd9,  16'hBEEF);
            chk_frame("R7 park", k + 2, 2'b01, 5'(ports[i]), 5'd31, 16'h0003);
            k += 3;
        end
    endtask

    task automatic t_badport();
        logic [31:0] v;
        int n;
        nfr = 0;
        host_wr(2'd2, {16'd40, 16'h1234});
        run_cmd(mk(2, 0, 12'h001, 1'b0, 1'b1), n);
        check("R5 frames", 32'(nfr), 32'd0);
        check("R5 fast", 32'(n <= 4), 32'd1);
        host_rd(2'd2, v);
        check("R5 result", v, {16'd40, 16'hFFFF});
    endtask

    task automatic t_empty();
        int n;
        nfr = 0;
        host_wr(2'd0, 32'h0);
        run_cmd(mk(1, 0, 12'h001, 1'b1, 1'b1), n);
        check("R9 frames", 32'(nfr), 32'd0);
        check("R9 done", 32'(n < 100), 32'd1);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        int n;
        nfr = 0;
        host_wr(2'd0, 32'h0000_00F0);
        host_wr(2'd2, {16'd1, 16'h0});
        host_wr(2'd1, mk(3, 2, 12'h010, 1'b0, 1'b1));
        repeat (50) @(negedge clk);
        host_wr(2'd0, 32'hFFFF_FFFF);
        host_wr(2'd2, 32'hAAAA_5555);
        host_wr(2'd1, mk(6, 1, 12'h0FF, 1'b1, 1'b0));
        host_rd(2'd1, v);
        check("R2 busy held", v[0], 32'd1);
        wait_idle(n);
        repeat (600) @(negedge clk);
        check("R2 no extra cmd", 32'(nfr), 32'd3);
        host_rd(2'd0, v);
        check("R2 mask locked", v, 32'h0000_00F0);
        host_rd(2'd2, v);
        check("R2 data locked", v, {16'd1, rvf(5'd1, 12'h010, 5'd3)});
    endtask

    task automatic t_mdc();
        time t1, t2;
        int n;
        host_wr(2'd2, {16'd2, 16'h0});
        host_wr(2'd1, mk(1, 0, 12'h004, 1'b0, 1'b0));
        @(posedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        check("R8 period", 32'((t2 - t1) / 8), 32'd4);
        wait_idle(n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read();
        t_nopark();
        t_write();
        t_badport();
        t_empty();
        t_locked();
        t_mdc();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule